// File: doc/BRIEF.md
# Gigabit Receive Frame Checker

This block sits behind an 8-bit gigabit media-independent receive interface. It takes one byte per clock together with a data-valid and an error strobe. It looks for the start of each frame and forwards every frame byte, from the destination address through the four check bytes, to a downstream stream. While the bytes pass, it runs a CRC-32 over them and tracks the frame length. It also notes whether an 802.1Q tag follows the source address, and whether the interface raised its error strobe.

When data-valid drops, the last byte leaves the block with an end marker. That cycle also carries a good or bad verdict, a status code and the frame's byte count. Two counters record how many frames passed and how many were dropped. An optional mode refuses any frame whose start delimiter arrives too soon after the previous frame ended. The block keeps no frame storage, so a downstream consumer discards bad frames based on the verdict at the end marker.

Top module: `gmii_rx_checker`

## Requirements
- R1: A frame begins only when a 0xD5 delimiter byte arrives right after at least seven consecutive 0x55 bytes, all with data-valid high. A shorter run, or a run broken by any other byte before the delimiter, yields no output and no count.
- R2: Each frame byte after the delimiter, up to the last byte before data-valid falls, appears once and in order on `outData` with `outValid`, exactly two clocks after it was presented. `outSof` marks the first byte and `outEof` marks the last.
- R3: The CRC-32 (generator 0x04C11DB7, preset all ones, bits taken LSB first) runs over every frame byte, the FCS included. A frame whose result differs from the fixed good-frame residue ends with status 1 (CRC error). A frame that passes every check ends with status 0 and `outGood`.
- R4: A frame of fewer than MIN_FRAME (64) bytes, the FCS included, ends with status 2 (runt).
- R5: A frame longer than MAX_FRAME (1518) bytes ends with status 3 (oversize). The limit rises by four bytes when frame bytes 12 and 13 (counting from 0) are 0x81 and 0x00.
- R6: If `rxErr` is high on any valid frame byte, the frame ends with status 4 (PHY error). Status priority runs PHY error, runt, oversize, then CRC error.
- R7: The end marker carries the frame byte count on `outLen` and exactly one of `outGood` and `outBad`. Both verdict flags stay low on all other cycles.
- R8: `goodCount` rises by one for each frame ending good and `dropCount` by one for each frame ending bad. Neither changes on any other cycle.
- R9: While `ipgCheckEn` is high, a delimiter is refused unless at least MIN_GAP (12) cycles with data-valid low have passed since the last accepted frame's final byte. While it is low, the gap is not checked.
- R10: After reset no output is valid and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rstN | input | 1 | Synchronous active-low reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Byte is part of a transmission |
| rxErr | input | 1 | Interface reports a line error on this byte |
| ipgCheckEn | input | 1 | Enforce the minimum idle gap |
| outData | output | 8 | Forwarded frame byte |
| outValid | output | 1 | `outData` holds a frame byte |
| outSof | output | 1 | First byte of a frame |
| outEof | output | 1 | Last byte of a frame, verdict valid |
| outGood | output | 1 | Frame ended good (with `outEof`) |
| outBad | output | 1 | Frame ended bad (with `outEof`) |
| outStatus | output | 3 | 0 good, 1 CRC, 2 runt, 3 oversize, 4 PHY error |
| outLen | output | 16 | Frame byte count, FCS included |
| goodCount | output | CNT_W (32) | Frames ended good |
| dropCount | output | CNT_W (32) | Frames ended bad |

## Verification
The stimulus covers several frame shapes:
- clean frames of minimum, medium and maximum size, which confirm the CRC residue and the length bounds;
- a frame with a flipped FCS bit, which separates the CRC path from the length checks;
- frames one byte past each limit, with and without a VLAN tag, which show the tag raises the ceiling by exactly four bytes;
- frames with the error strobe raised on a clean frame and on a short, corrupted one, which show PHY-error priority.

Preambles that are too short, broken, or longer than seven bytes test the delimiter hunt. Gaps of eleven and twelve idle cycles, with enforcement on and off, pin the idle-gap threshold to the exact cycle.

// File: rtl/gmii_rxchk_pkg.sv
package gmii_rxchk_pkg;

  // Width of the frame length field carried on the end marker.
  localparam int LEN_W = 16;

  // Reflected generator (bit-reverse of 0x04C11DB7) for LSB-first processing.
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  // Good-frame residue in reflected register order (0xC704DD7B bit-reversed).
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;

  typedef enum logic [2:0] {
    ST_GOOD     = 3'd0,
    ST_CRC      = 3'd1,
    ST_RUNT     = 3'd2,
    ST_OVERSIZE = 3'd3,
    ST_PHY      = 3'd4
  } rxStatus_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             startFrame;
    logic             takeByte;
    logic             endFrame;
    rxStatus_e        status;
    logic [LEN_W-1:0] frameLen;
  } rxStrobes_t;

  function automatic logic [31:0] crcByte(input logic [31:0] cur, input logic [7:0] din);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ din[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/gmii_rxchk_ctrl.sv
module gmii_rxchk_ctrl
  import gmii_rxchk_pkg::*;
#(
  parameter int PRE_LEN    = 7,
  parameter int MIN_GAP    = 12,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       rxErr,
  input  logic       ipgCheckEn,
  input  logic       crcOk,
  output rxStrobes_t strobes
);

  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(PRE_LEN);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(MIN_GAP);
  localparam logic [LEN_W-1:0] TPID_POS = LEN_W'(2 * ADDR_BYTES);
  localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] LEN_VMAX = LEN_W'(MAX_FRAME + VLAN_EXTRA);
  localparam logic [LEN_W-1:0] LEN_SAT  = '1;

  typedef enum logic {HUNT, FRAME} rxState_e;

  rxState_e         state;
  logic [PRE_W-1:0] preCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [LEN_W-1:0] byteCnt;
  logic             errSeen;
  logic             tpidHi;
  logic             vlanSeen;

  logic             gapOk;
  logic             sfdHit;
  logic [LEN_W-1:0] lenLimit;
  rxStatus_e        endStatus;

  assign gapOk  = !ipgCheckEn || (gapCnt == GAP_MAX);
  assign sfdHit = rxValid && (rxData == 8'hD5) && (preCnt == PRE_MAX) && gapOk;

  assign lenLimit = vlanSeen ? LEN_VMAX : LEN_MAX;

  always_comb begin
    if (errSeen)                endStatus = ST_PHY;
    else if (byteCnt < LEN_MIN) endStatus = ST_RUNT;
    else if (byteCnt > lenLimit) endStatus = ST_OVERSIZE;
    else if (!crcOk)            endStatus = ST_CRC;
    else                        endStatus = ST_GOOD;
  end

  always_comb begin
    strobes.startFrame = (state == HUNT) && sfdHit;
    strobes.takeByte   = (state == FRAME) && rxValid;
    strobes.endFrame   = (state == FRAME) && !rxValid;
    strobes.status     = endStatus;
    strobes.frameLen   = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= HUNT;
      preCnt   <= '0;
      gapCnt   <= GAP_MAX;
      byteCnt  <= '0;
      errSeen  <= 1'b0;
      tpidHi   <= 1'b0;
      vlanSeen <= 1'b0;
    end else begin
      unique case (state)
        HUNT: begin
          if (!rxValid) begin
            preCnt <= '0;
            if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;
          end else if (sfdHit) begin
            state    <= FRAME;
            preCnt   <= '0;
            byteCnt  <= '0;
            errSeen  <= 1'b0;
            tpidHi   <= 1'b0;
            vlanSeen <= 1'b0;
          end else if (rxData == 8'h55) begin
            if (preCnt != PRE_MAX) preCnt <= preCnt + 1'b1;
          end else begin
            preCnt <= '0;
          end
        end
        FRAME: begin
          if (rxValid) begin
            if (byteCnt != LEN_SAT) byteCnt <= byteCnt + 1'b1;
            errSeen <= errSeen | rxErr;
            if (byteCnt == TPID_POS) tpidHi <= (rxData == 8'h81);
            if (byteCnt == TPID_POS + 1'b1) vlanSeen <= tpidHi && (rxData == 8'h00);
          end else begin
            state  <= HUNT;
            preCnt <= '0;
            gapCnt <= GAP_W'(1);
          end
        end
        default: state <= HUNT;
      endcase
    end
  end

endmodule

// File: rtl/gmii_rxchk_dp.sv
module gmii_rxchk_dp
  import gmii_rxchk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  rxStrobes_t       strobes,
  output logic             crcOk,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outSof,
  output logic             outEof,
  output logic             outGood,
  output logic             outBad,
  output logic [2:0]       outStatus,
  output logic [LEN_W-1:0] outLen,
  output logic [CNT_W-1:0] goodCount,
  output logic [CNT_W-1:0] dropCount
);

  logic [31:0] crcReg;
  logic [7:0]  holdData;
  logic        holdValid;
  logic        holdFirst;
  logic        isGood;

  assign crcOk  = (crcReg == CRC_RESIDUE_REFL);
  assign isGood = (strobes.status == ST_GOOD);

  // Running CRC over the frame bytes.
  always_ff @(posedge clk) begin
    if (!rstN)                   crcReg <= '1;
    else if (strobes.startFrame) crcReg <= '1;
    else if (strobes.takeByte)   crcReg <= crcByte(crcReg, rxData);
  end

  // One-byte hold so the final byte can be tagged when valid falls.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData  <= '0;
      holdValid <= 1'b0;
      holdFirst <= 1'b0;
    end else if (strobes.startFrame || strobes.endFrame) begin
      holdValid <= 1'b0;
      holdFirst <= 1'b0;
    end else if (strobes.takeByte) begin
      holdData  <= rxData;
      holdValid <= 1'b1;
      holdFirst <= !holdValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outValid  <= 1'b0;
      outSof    <= 1'b0;
      outEof    <= 1'b0;
      outGood   <= 1'b0;
      outBad    <= 1'b0;
      outStatus <= '0;
      outLen    <= '0;
    end else begin
      outData   <= holdData;
      outValid  <= holdValid && (strobes.takeByte || strobes.endFrame);
      outSof    <= holdValid && holdFirst && (strobes.takeByte || strobes.endFrame);
      outEof    <= holdValid && strobes.endFrame;
      outGood   <= holdValid && strobes.endFrame && isGood;
      outBad    <= holdValid && strobes.endFrame && !isGood;
      outStatus <= (holdValid && strobes.endFrame) ? strobes.status : 3'd0;
      outLen    <= (holdValid && strobes.endFrame) ? strobes.frameLen : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCount <= '0;
      dropCount <= '0;
    end else if (strobes.endFrame && holdValid) begin
      if (isGood) goodCount <= goodCount + 1'b1;
      else        dropCount <= dropCount + 1'b1;
    end
  end

endmodule

// File: rtl/gmii_rx_checker.sv
module gmii_rx_checker
  import gmii_rxchk_pkg::*;
#(
  parameter int PRE_LEN    = 7,
  parameter int MIN_GAP    = 12,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  input  logic             rxErr,
  input  logic             ipgCheckEn,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outSof,
  output logic             outEof,
  output logic             outGood,
  output logic             outBad,
  output logic [2:0]       outStatus,
  output logic [LEN_W-1:0] outLen,
  output logic [CNT_W-1:0] goodCount,
  output logic [CNT_W-1:0] dropCount
);

  rxStrobes_t strobes;
  logic       crcOk;

  gmii_rxchk_ctrl #(
    .PRE_LEN(PRE_LEN), .MIN_GAP(MIN_GAP), .MIN_FRAME(MIN_FRAME),
    .MAX_FRAME(MAX_FRAME), .VLAN_EXTRA(VLAN_EXTRA), .ADDR_BYTES(ADDR_BYTES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxErr(rxErr),
    .ipgCheckEn(ipgCheckEn), .crcOk(crcOk), .strobes(strobes)
  );

  gmii_rxchk_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .strobes(strobes), .crcOk(crcOk),
    .outData(outData), .outValid(outValid), .outSof(outSof), .outEof(outEof),
    .outGood(outGood), .outBad(outBad), .outStatus(outStatus), .outLen(outLen),
    .goodCount(goodCount), .dropCount(dropCount)
  );

endmodule

// File: rtl/gmii_rx_checker_chk.sv
module gmii_rx_checker_chk #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int CNT_W     = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outSof,
  input logic             outEof,
  input logic             outGood,
  input logic             outBad,
  input logic [2:0]       outStatus,
  input logic [15:0]      outLen,
  input logic [CNT_W-1:0] goodCount,
  input logic [CNT_W-1:0] dropCount
);

  // R2
  sof_in_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);

  // R7
  eof_in_stream_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> outValid);

  // R7
  verdict_on_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outGood || outBad) |-> outEof);

  // R7
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> (outGood ^ outBad));

  // R3
  good_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> (outGood == (outStatus == 3'd0)));

  // R4
  runt_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEof && (outLen < 16'(MIN_FRAME)) && (outStatus != 3'd4)) |-> (outStatus == 3'd2));

  // R5
  oversize_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEof && (outStatus == 3'd3)) |-> (outLen > 16'(MAX_FRAME)));

  // R8
  good_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outGood |-> (goodCount == $past(goodCount) + 1'b1));

  // R8
  drop_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outBad |-> (dropCount == $past(dropCount) + 1'b1));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEof |-> ($stable(goodCount) && $stable(dropCount)));

endmodule

bind gmii_rx_checker gmii_rx_checker_chk #(
  .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)
) chk_i (.*);

// File: tb/gmii_rx_checker_tb.sv
module gmii_rx_checker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxValid = 1'b0;
  logic        rxErr = 1'b0;
  logic        ipgCheckEn = 1'b0;
  logic [7:0]  outData;
  logic        outValid, outSof, outEof, outGood, outBad;
  logic [2:0]  outStatus;
  logic [15:0] outLen;
  logic [31:0] goodCount, dropCount;

  always #5 clk = ~clk;

  gmii_rx_checker dut_i (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxErr(rxErr),
    .ipgCheckEn(ipgCheckEn), .outData(outData), .outValid(outValid), .outSof(outSof),
    .outEof(outEof), .outGood(outGood), .outBad(outBad), .outStatus(outStatus),
    .outLen(outLen), .goodCount(goodCount), .dropCount(dropCount)
  );

  typedef struct {
    int        cyc;
    logic [7:0] d;
    bit        sof;
    bit        eof;
    int        st;
    int        len;
  } exp_t;

  exp_t       expQ[$];
  logic [7:0] fr[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  int         modelGood = 0;
  int         modelDrop = 0;
  bit         monOn = 0;
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  function automatic string stTag(input int st);
    case (st)
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R3";
    endcase
  endfunction

  // Reference model: compare every clock against the expected byte schedule.
  always @(negedge clk) begin
    if (monOn) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        check(outValid == 1'b1, "R2", "outValid", int'(outValid), 1);
        check(outData == e.d, "R2", "outData", int'(outData), int'(e.d));
        check(outSof == e.sof, "R2", "outSof", int'(outSof), int'(e.sof));
        check(outEof == e.eof, "R2", "outEof", int'(outEof), int'(e.eof));
        if (e.eof) begin
          if (e.st == 0) modelGood++;
          else modelDrop++;
          check(int'(outStatus) == e.st, stTag(e.st), "outStatus", int'(outStatus), e.st);
          check(int'(outLen) == e.len, "R7", "outLen", int'(outLen), e.len);
          check(outGood == (e.st == 0), "R7", "outGood", int'(outGood), int'(e.st == 0));
          check(outBad == (e.st != 0), "R7", "outBad", int'(outBad), int'(e.st != 0));
        end else begin
          check(!outGood && !outBad, "R7", "verdict off end", int'({outGood, outBad}), 0);
        end
      end else begin
        check(outValid == 1'b0, "R1/R9", "unexpected outValid", int'(outValid), 0);
      end
      check(int'(goodCount) == modelGood, "R8", "goodCount", int'(goodCount), modelGood);
      check(int'(dropCount) == modelDrop, "R8", "dropCount", int'(dropCount), modelDrop);
    end
  end

  task automatic drive(input logic [7:0] d, input logic v, input logic e);
    @(negedge clk);
    rxData  = d;
    rxValid = v;
    rxErr   = e;
  endtask

  function automatic logic [31:0] crcNormal();
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFFFFFF;
    foreach (fr[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ fr[k][i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return ~c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic buildFrame(input int totalLen, input bit vlan, input bit badCrc);
    logic [31:0] f;
    fr.delete();
    fr.push_back(8'h02); fr.push_back(8'h11); fr.push_back(8'h22);
    fr.push_back(8'h33); fr.push_back(8'h44); fr.push_back(8'h55);
    fr.push_back(8'h02); fr.push_back(8'hAA); fr.push_back(8'hBB);
    fr.push_back(8'hCC); fr.push_back(8'hDD); fr.push_back(8'hEE);
    if (vlan) begin
      fr.push_back(8'h81); fr.push_back(8'h00); fr.push_back(8'h20); fr.push_back(8'h05);
    end
    fr.push_back(8'h08); fr.push_back(8'h00);
    for (int i = 0; fr.size() < totalLen - 4; i++) fr.push_back(8'((i * 13 + 1) & 255));
    f = crcNormal();
    fr.push_back(rev8(f[31:24]) ^ {7'd0, badCrc});
    fr.push_back(rev8(f[23:16]));
    fr.push_back(rev8(f[15:8]));
    fr.push_back(rev8(f[7:0]));
  endtask

  // Sends preamble, delimiter and the built frame, then idles.
  task automatic sendFrame(input int preLen, input int cutAt, input bit accept,
                           input int errIdx, input int expSt, input int gapAfter);
    int last;
    last = fr.size() - 1;
    for (int i = 0; i < preLen; i++) drive((i == cutAt) ? 8'h3C : 8'h55, 1'b1, 1'b0);
    drive(8'hD5, 1'b1, 1'b0);
    for (int i = 0; i <= last; i++) begin
      drive(fr[i], 1'b1, (i == errIdx) ? 1'b1 : 1'b0);
      if (accept) begin
        exp_t e;
        e.cyc = cyc + 2;
        e.d   = fr[i];
        e.sof = (i == 0);
        e.eof = (i == last);
        e.st  = expSt;
        e.len = last + 1;
        expQ.push_back(e);
      end
    end
    for (int i = 0; i < gapAfter; i++) drive(8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs and counters during reset
    check(outValid == 1'b0, "R10", "outValid in reset", int'(outValid), 0);
    check(goodCount == 32'd0, "R10", "goodCount in reset", int'(goodCount), 0);
    check(dropCount == 32'd0, "R10", "dropCount in reset", int'(dropCount), 0);
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (3) drive(8'h00, 1'b0, 1'b0);

    buildFrame(64, 0, 0);   sendFrame(7, -1, 1, -1, 0, 12);   // R3 minimum good
    buildFrame(100, 0, 0);  sendFrame(7, -1, 1, -1, 0, 12);   // R3
    buildFrame(64, 0, 1);   sendFrame(7, -1, 1, -1, 1, 12);   // R3 CRC error
    buildFrame(63, 0, 0);   sendFrame(7, -1, 1, -1, 2, 12);   // R4 runt
    buildFrame(1518, 0, 0); sendFrame(7, -1, 1, -1, 0, 12);   // R5 at limit
    buildFrame(1519, 0, 0); sendFrame(7, -1, 1, -1, 3, 12);   // R5 oversize
    buildFrame(1522, 1, 0); sendFrame(7, -1, 1, -1, 0, 12);   // R5 tagged at limit
    buildFrame(1523, 1, 0); sendFrame(7, -1, 1, -1, 3, 12);   // R5 tagged oversize
    buildFrame(80, 0, 0);   sendFrame(7, -1, 1, 30, 4, 12);   // R6 error strobe
    buildFrame(40, 0, 1);   sendFrame(7, -1, 1, 5, 4, 12);    // R6 priority over runt/CRC
    buildFrame(70, 0, 0);   sendFrame(10, -1, 1, -1, 0, 12);  // R1 long preamble
    buildFrame(64, 0, 0);   sendFrame(6, -1, 0, -1, 0, 12);   // R1 six bytes only
    buildFrame(64, 0, 0);   sendFrame(9, 3, 0, -1, 0, 12);    // R1 broken preamble
    buildFrame(65, 0, 0);   sendFrame(7, -1, 1, -1, 0, 12);   // R1 recovers

    ipgCheckEn = 1'b1;
    buildFrame(64, 0, 0);   sendFrame(7, -1, 1, -1, 0, 11);   // R9
    buildFrame(64, 0, 0);   sendFrame(7, -1, 0, -1, 0, 12);   // R9 refused after 11 idle
    buildFrame(66, 0, 0);   sendFrame(7, -1, 1, -1, 0, 12);   // R9 accepted
    buildFrame(64, 0, 0);   sendFrame(7, -1, 1, -1, 0, 3);    // R9 after exactly 12
    ipgCheckEn = 1'b0;
    buildFrame(68, 0, 1);   sendFrame(7, -1, 1, -1, 1, 12);   // R9 disabled, 3-cycle gap

    repeat (5) drive(8'h00, 1'b0, 1'b0);
    check(expQ.size() == 0, "R2", "pending expected bytes", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule